// File: doc/BRIEF.md
# TDM Slot Receive Deserializer

This block turns the serial data line of a time-division-multiplexed audio link into parallel words. A frame timing generator elsewhere supplies single-cycle strobes for the rising and falling bit-clock edges and a marker for the first bit of each frame. The deserializer samples the data line on the edge chosen by a polarity input. It follows the bit and slot position inside the frame, and it pulls one word out of each active slot. A slot can be longer than the word it carries, so the word is taken either from the start or from the end of the slot.

Completed words go into a 32-entry first-in first-out buffer with a show-ahead read port. A request line asks a DMA engine to empty the buffer once its fill level reaches a half or quarter threshold. A word that arrives at a full buffer is discarded, and a sticky flag records the loss. The receive configuration arrives as one 12-bit control word from the register file. Clearing its enable bit halts capture and leaves every other field as it was, so a later restart uses the same settings.

Top module: `tdm_rx_deser`

## Requirements
- R1: After reset the buffer is empty (`rd_empty`=1, `rd_full`=0, `rd_level`=0), and `dma_req` and `overrun` are 0.
- R2: With `clk_pol`=0 the data line is sampled only in cycles where `bclk_fall` is high. With `clk_pol`=1 it is sampled only where `bclk_rise` is high. The other strobe has no effect on captured data.
- R3: A sample taken while `frame_mark` is high is bit 0 of slot 0. Later samples advance the bit index, and the slot index moves on after the last bit of a slot. Serial data is most-significant bit first. The slot length field `rx_ctrl[3:2]` selects 8 (code 0), 16 (code 1) or 32 (codes 2 and 3) bits.
- R4: With `rx_ctrl[1]`=1 (left-justified) the word is the first bits of the slot.
- R5: With `rx_ctrl[1]`=0 (right-justified) the word is the last bits of the slot.
- R6: The word length field `rx_ctrl[10:8]` selects 8, 16, 20, 24 or 32 bits (codes 0 to 3; codes 4 to 7 mean 32). A word longer than the slot is cut down to the slot length. Each stored word is right-aligned in `rd_data` and zero-extended.
- R7: Only slots with an index below the count field `rx_ctrl[7:4]` are captured. Later slots in the frame add nothing to the buffer.
- R8: While the enable bit `rx_ctrl[0]` is 0 nothing is captured and frame alignment is lost. After re-enabling, capture starts only at the next `frame_mark`.
- R9: Words leave the buffer in arrival order. `rd_data` shows the oldest word, `rd_en` removes it, and `rd_level`, `rd_empty` and `rd_full` track the occupancy.
- R10: `dma_req` is high exactly when `rd_level` is at least 16 with `rx_ctrl[11]`=0, or at least 8 with `rx_ctrl[11]`=1.
- R11: A word that completes while the buffer is full and no read is taking place is dropped, and `overrun` is set and stays set until reset.
- R12: If a word completes in the same cycle as a read of a full buffer, both take effect: the buffer stays full, the new word is kept and `overrun` does not rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_ctrl | input | 12 | Receive control word (enable, justification, slot length, slot count, word length, threshold) |
| clk_pol | input | 1 | 0: sample on falling-edge strobe; 1: sample on rising-edge strobe |
| bclk_rise | input | 1 | Strobe for a rising bit-clock edge |
| bclk_fall | input | 1 | Strobe for a falling bit-clock edge |
| frame_mark | input | 1 | High on the sample of the first bit of a frame |
| sdata | input | 1 | Serial receive data |
| rd_en | input | 1 | Remove the word shown on `rd_data` |
| rd_data | output | 32 | Oldest buffered word |
| rd_empty | output | 1 | Buffer holds no word |
| rd_full | output | 1 | Buffer holds 32 words |
| rd_level | output | 6 | Number of buffered words |
| dma_req | output | 1 | Fill level at or above the selected threshold |
| overrun | output | 1 | Sticky: a word was lost to a full buffer |

## Verification
Two functions can fall in the same cycle: a word completing into the buffer and a read draining it. The hard case is a full buffer. To provoke it, the bench fills the buffer to 32 and then sends a one-slot frame. It holds `rd_en` for exactly the cycle in which the last bit's word reaches the buffer, one cycle after the final sampling strobe. The result is judged at the ports. The word popped must be the oldest one, the level must stay at 32 and `overrun` must stay low. The following drain must then return the new word last. A second word sent with no read must then be dropped and set the flag.

// File: rtl/tdm_rx_pkg.sv
`timescale 1ns/1ps
package tdm_rx_pkg;

   localparam int CTRL_W = 12;

   typedef struct packed {
      logic       en;
      logic       lj;
      logic [5:0] slot_len;
      logic [5:0] word_len;
      logic [3:0] slot_cnt;
      logic       quarter;
   } rx_cfg_t;

   function automatic logic [5:0] slot_len_of(input logic [1:0] code);
      case (code)
         2'd0:    return 6'd8;
         2'd1:    return 6'd16;
         default: return 6'd32;
      endcase
   endfunction

   function automatic logic [5:0] word_len_of(input logic [2:0] code);
      case (code)
         3'd0:    return 6'd8;
         3'd1:    return 6'd16;
         3'd2:    return 6'd20;
         3'd3:    return 6'd24;
         default: return 6'd32;
      endcase
   endfunction

   function automatic rx_cfg_t decode_ctrl(input logic [CTRL_W-1:0] w);
      rx_cfg_t    r;
      logic [5:0] wl;
      r.en       = w[0];
      r.lj       = w[1];
      r.slot_len = slot_len_of(w[3:2]);
      r.slot_cnt = w[7:4];
      wl         = word_len_of(w[10:8]);
      r.word_len = (wl > r.slot_len) ? r.slot_len : wl;
      r.quarter  = w[11];
      return r;
   endfunction

endpackage

// File: rtl/tdm_rx_slot_track.sv
`timescale 1ns/1ps
module tdm_rx_slot_track #(
   parameter int CNT_W = 4,
   parameter int BIT_W = 5,
   parameter int LEN_W = BIT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             smp,
   input  logic             frame_mark,
   input  logic [LEN_W-1:0] slot_len,
   input  logic [CNT_W-1:0] slot_cnt,
   output logic             cap,
   output logic [BIT_W-1:0] cap_bit
);
   localparam int SLOT_W = CNT_W + 1;

   logic [BIT_W-1:0]  bit_q, cur_bit, last_bit;
   logic [SLOT_W-1:0] slot_q, cur_slot;
   logic              synced_q, cur_vld;

   assign last_bit = BIT_W'(slot_len - LEN_W'(1));

   always_comb begin
      cur_bit  = bit_q;
      cur_slot = slot_q;
      cur_vld  = 1'b0;
      if (frame_mark) begin
         cur_bit  = '0;
         cur_slot = '0;
         cur_vld  = 1'b1;
      end else if (synced_q) begin
         cur_vld = 1'b1;
         if (bit_q == last_bit) begin
            cur_bit  = '0;
            cur_slot = (&slot_q) ? slot_q : slot_q + 1'b1;
         end else begin
            cur_bit = bit_q + 1'b1;
         end
      end
   end

   assign cap     = en & smp & cur_vld & (cur_slot < {1'b0, slot_cnt});
   assign cap_bit = cur_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_q    <= '0;
         slot_q   <= '0;
         synced_q <= 1'b0;
      end else if (!en) begin
         synced_q <= 1'b0;
      end else if (smp) begin
         bit_q    <= cur_bit;
         slot_q   <= cur_slot;
         synced_q <= cur_vld;
      end
   end

   // R8: a disabled cycle leaves the tracker unaligned
   a_r8_disable_unsyncs: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !synced_q);

   // R3: alignment is only gained through a frame marker
   a_r3_sync_needs_mark: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(synced_q) |-> $past(frame_mark && smp));

endmodule

// File: rtl/tdm_rx_word_asm.sv
`timescale 1ns/1ps
module tdm_rx_word_asm #(
   parameter int DATA_W = 32,
   parameter int BIT_W  = 5,
   parameter int LEN_W  = BIT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [BIT_W-1:0]  cap_bit,
   input  logic              sdata,
   input  logic              lj,
   input  logic [LEN_W-1:0]  slot_len,
   input  logic [LEN_W-1:0]  word_len,
   output logic              push,
   output logic [DATA_W-1:0] word
);
   logic [LEN_W-1:0]  first_b, last_b, bit_ix;
   logic [DATA_W-1:0] sh_q, next_sh, word_q;
   logic              push_q, in_word;

   always_comb begin
      if (lj) begin
         first_b = '0;
         last_b  = word_len - LEN_W'(1);
      end else begin
         first_b = slot_len - word_len;
         last_b  = slot_len - LEN_W'(1);
      end
   end

   assign bit_ix  = LEN_W'(cap_bit);
   assign in_word = (bit_ix >= first_b) && (bit_ix <= last_b);
   assign next_sh = (bit_ix == first_b) ? {{(DATA_W-1){1'b0}}, sdata}
                                        : {sh_q[DATA_W-2:0], sdata};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         word_q <= '0;
         push_q <= 1'b0;
      end else begin
         push_q <= 1'b0;
         if (cap && in_word) begin
            sh_q <= next_sh;
            if (bit_ix == last_b) begin
               push_q <= 1'b1;
               word_q <= next_sh;
            end
         end
      end
   end

   assign push = push_q;
   assign word = word_q;

   // R6: bits above the word length are zero
   a_r6_zero_extend: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> ((word >> $past(word_len)) == '0));

   // R3: a word needs at least eight samples, so pushes never abut
   a_r3_push_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> !push);

endmodule

// File: rtl/tdm_rx_fifo.sv
`timescale 1ns/1ps
module tdm_rx_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   parameter int AW     = $clog2(DEPTH),
   parameter int LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd,
   output logic [DATA_W-1:0] rdata,
   output logic              empty,
   output logic              full,
   output logic [LVL_W-1:0]  level,
   output logic              ovr
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [LVL_W-1:0]  count;
   logic              pop, acc, ovr_q;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_mod
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign empty = (count == '0);
   assign full  = (count == LVL_W'(DEPTH));
   assign pop   = rd & ~empty;
   assign acc   = wr & (~full | pop);

   always_ff @(posedge clk) begin
      if (acc) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovr_q  <= 1'b0;
      end else begin
         if (acc) wr_ptr <= wr_nxt;
         if (pop) rd_ptr <= rd_nxt;
         case ({acc, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (wr && !acc) ovr_q <= 1'b1;
      end
   end

   assign rdata = mem[rd_ptr];
   assign level = count;
   assign ovr   = ovr_q;

   // R9: occupancy never exceeds the depth
   a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

   // R9: reading an empty buffer changes nothing
   a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd && !wr) |=> empty);

   // R11: the loss flag is sticky
   a_r11_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |=> ovr);

   // R11: a write into a full buffer without a read is lost
   a_r11_drop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr && !rd) |=> (ovr && full));

   // R12: a write and a read on a full buffer both succeed
   a_r12_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr && rd) |=> (full && $stable(ovr)));

endmodule

// File: rtl/tdm_rx_deser.sv
`timescale 1ns/1ps
module tdm_rx_deser
   import tdm_rx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   parameter int LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] rx_ctrl,
   input  logic              clk_pol,
   input  logic              bclk_rise,
   input  logic              bclk_fall,
   input  logic              frame_mark,
   input  logic              sdata,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_empty,
   output logic              rd_full,
   output logic [LVL_W-1:0]  rd_level,
   output logic              dma_req,
   output logic              overrun
);
   localparam int BIT_W  = 5;
   localparam int LEN_W  = BIT_W + 1;
   localparam int CNT_W  = 4;
   localparam int THR_HI = DEPTH / 2;
   localparam int THR_LO = DEPTH / 4;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("tdm_rx_deser: DATA_W must be 32 to hold a full slot");
      end
      if (DEPTH < 4 || (DEPTH % 4) != 0) begin : g_bad_depth
         $error("tdm_rx_deser: DEPTH must be a multiple of 4");
      end
   endgenerate

   rx_cfg_t           cfg;
   logic              smp, cap, push;
   logic [BIT_W-1:0]  cap_bit;
   logic [DATA_W-1:0] word;
   logic [LVL_W-1:0]  thr;

   assign cfg = decode_ctrl(rx_ctrl);
   assign smp = clk_pol ? bclk_rise : bclk_fall;

   tdm_rx_slot_track #(.CNT_W(CNT_W), .BIT_W(BIT_W), .LEN_W(LEN_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (cfg.en),
      .smp        (smp),
      .frame_mark (frame_mark),
      .slot_len   (cfg.slot_len),
      .slot_cnt   (cfg.slot_cnt),
      .cap        (cap),
      .cap_bit    (cap_bit)
   );

   tdm_rx_word_asm #(.DATA_W(DATA_W), .BIT_W(BIT_W), .LEN_W(LEN_W)) u_asm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (cap),
      .cap_bit  (cap_bit),
      .sdata    (sdata),
      .lj       (cfg.lj),
      .slot_len (cfg.slot_len),
      .word_len (cfg.word_len),
      .push     (push),
      .word     (word)
   );

   tdm_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (push),
      .wdata (word),
      .rd    (rd_en),
      .rdata (rd_data),
      .empty (rd_empty),
      .full  (rd_full),
      .level (rd_level),
      .ovr   (overrun)
   );

   assign thr     = cfg.quarter ? LVL_W'(THR_LO) : LVL_W'(THR_HI);
   assign dma_req = (rd_level >= thr);

   // R8: a word only arrives from a capture made while enabled
   a_r8_push_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> $past(cfg.en));

   // R10: an empty buffer never requests service
   a_r10_no_req_empty: assert property (@(posedge clk) disable iff (!rst_n)
      rd_empty |-> !dma_req);

endmodule

// File: tb/tdm_rx_deser_test.sv
`timescale 1ns/1ps
module tdm_rx_deser_test;
   localparam int DEPTH = 32;
   localparam int NVEC  = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [11:0] rx_ctrl;
   logic        clk_pol, bclk_rise, bclk_fall, frame_mark, sdata, rd_en;
   logic [31:0] rd_data;
   logic        rd_empty, rd_full, dma_req, overrun;
   logic [5:0]  rd_level;

   always #2.5 clk = ~clk;

   tdm_rx_deser uut (
      .clk(clk), .rst_n(rst_n), .rx_ctrl(rx_ctrl), .clk_pol(clk_pol),
      .bclk_rise(bclk_rise), .bclk_fall(bclk_fall), .frame_mark(frame_mark),
      .sdata(sdata), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty),
      .rd_full(rd_full), .rd_level(rd_level), .dma_req(dma_req), .overrun(overrun)
   );

   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;
   logic [31:0] mq [64];
   int          mh, mt, mcnt;

   function automatic logic [11:0] mk(bit en, bit lj, int slc, int cnt, int wlc, bit q);
      return {q, 3'(wlc), 4'(cnt), 2'(slc), lj, en};
   endfunction

   function automatic int sl_of(logic [1:0] c);
      return (c == 2'd0) ? 8 : (c == 2'd1) ? 16 : 32;
   endfunction

   function automatic int wl_of(logic [2:0] c);
      case (c)
         3'd0: return 8;
         3'd1: return 16;
         3'd2: return 20;
         3'd3: return 24;
         default: return 32;
      endcase
   endfunction

   function automatic logic [31:0] slot_val(logic [15:0] seed, int k);
      return {seed, ~seed} ^ (32'h9E3779B9 * 32'(k + 1));
   endfunction

   function automatic logic [31:0] exp_word(logic [31:0] val, int sl, int wl, bit lj);
      longint v, m;
      int     e;
      e = (wl > sl) ? sl : wl;
      v = longint'(val) & ((64'd1 << sl) - 1);
      m = (64'd1 << e) - 1;
      if (lj) return 32'((v >> (sl - e)) & m);
      return 32'(v & m);
   endfunction

   // {pol, slots in frame, seed, control word}
   localparam logic [33:0] VEC [NVEC] = '{
      {1'b0, 5'd2, 16'hA5C3, mk(1, 1, 1, 2, 1, 0)},   // R4 16/16 left
      {1'b1, 5'd4, 16'h1234, mk(1, 1, 2, 4, 3, 0)},   // R2 R4 24 in 32
      {1'b0, 5'd6, 16'hBEEF, mk(1, 0, 2, 3, 2, 0)},   // R5 R7 20 in 32, 3 of 6
      {1'b1, 5'd8, 16'h0F0F, mk(1, 0, 1, 8, 0, 0)},   // R5 8 in 16
      {1'b0, 5'd4, 16'h7E81, mk(1, 1, 0, 1, 0, 0)},   // R7 one of four
      {1'b1, 5'd2, 16'hC001, mk(1, 1, 2, 2, 4, 0)},   // R6 full 32
      {1'b0, 5'd2, 16'h5A5A, mk(1, 0, 0, 2, 1, 0)},   // R6 clamp 16->8
      {1'b1, 5'd3, 16'h3C3C, mk(1, 1, 1, 3, 2, 0)}    // R6 clamp 20->16
   };

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; rx_ctrl = '0; clk_pol = 1'b0; bclk_rise = 1'b0;
      bclk_fall = 1'b0; frame_mark = 1'b0; sdata = 1'b0; rd_en = 1'b0;
      mh = 0; mt = 0; mcnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send_bit(bit b, bit mark);
      @(negedge clk);
      bclk_rise = 1'b1; bclk_fall = 1'b0; frame_mark = mark;
      sdata = clk_pol ? b : ~b;
      @(negedge clk);
      bclk_rise = 1'b0; bclk_fall = 1'b1; frame_mark = mark;
      sdata = clk_pol ? ~b : b;
   endtask

   task automatic send_frame(int nsl, logic [15:0] seed, bit mark, bit pop_last, bit cap_exp);
      int sl, wl, cnt;
      sl  = sl_of(rx_ctrl[3:2]);
      wl  = wl_of(rx_ctrl[10:8]);
      cnt = int'(rx_ctrl[7:4]);
      for (int k = 0; k < nsl; k++) begin
         logic [31:0] v;
         v = slot_val(seed, k);
         for (int b = 0; b < sl; b++)
            send_bit(v[sl-1-b], mark && k == 0 && b == 0);
      end
      @(negedge clk);
      bclk_rise = 1'b0; bclk_fall = 1'b0; frame_mark = 1'b0;
      if (pop_last) begin
         chk("R12 oldest word on simultaneous read", rd_data, mq[mh]);
         rd_en = 1'b1;
         mh = (mh + 1) % 64; mcnt--;
      end
      @(negedge clk);
      rd_en = 1'b0;
      repeat (2) @(negedge clk);
      if (cap_exp) begin
         for (int k = 0; k < nsl && k < cnt; k++) begin
            if (mcnt < DEPTH) begin
               mq[mt] = exp_word(slot_val(seed, k), sl, wl, rx_ctrl[1]);
               mt = (mt + 1) % 64; mcnt++;
            end
         end
      end
   endtask

   task automatic drain(string req);
      chk(req, 32'(rd_level), 32'(mcnt));
      while (mcnt > 0) begin
         chk(req, rd_data, mq[mh]);
         rd_en = 1'b1;
         @(negedge clk);
         rd_en = 1'b0;
         mh = (mh + 1) % 64; mcnt--;
      end
      chk(req, 32'(rd_empty), 32'd1);
   endtask

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 empty", 32'(rd_empty), 32'd1);
      chk("R1 full", 32'(rd_full), 32'd0);
      chk("R1 level", 32'(rd_level), 32'd0);
      chk("R1 req", 32'(dma_req), 32'd0);
      chk("R1 overrun", 32'(overrun), 32'd0);

      // table walk: R2 R3 R4 R5 R6 R7 R9
      for (int i = 0; i < NVEC; i++) begin
         rx_ctrl = VEC[i][11:0];
         clk_pol = VEC[i][33];
         send_frame(int'(VEC[i][32:28]), VEC[i][27:12], 1'b1, 1'b0, 1'b1);
         drain("R3 R4 R5 R6 R7 R9 vector");
      end

      // R8: disabled, then enabled without a marker, then with one
      rx_ctrl = mk(0, 1, 1, 2, 1, 0);
      clk_pol = 1'b0;
      send_frame(2, 16'h1111, 1'b1, 1'b0, 1'b0);
      chk("R8 disabled level", 32'(rd_level), 32'd0);
      rx_ctrl = mk(1, 1, 1, 2, 1, 0);
      send_frame(2, 16'h2222, 1'b0, 1'b0, 1'b0);
      chk("R8 no marker level", 32'(rd_level), 32'd0);
      send_frame(2, 16'h3333, 1'b1, 1'b0, 1'b1);
      drain("R8 resumed");

      // R10 thresholds
      rx_ctrl = mk(1, 1, 0, 7, 0, 1);
      send_frame(7, 16'h4444, 1'b1, 1'b0, 1'b1);
      chk("R10 quarter level 7", 32'(dma_req), 32'd0);
      rx_ctrl = mk(1, 1, 0, 1, 0, 1);
      send_frame(1, 16'h4545, 1'b1, 1'b0, 1'b1);
      chk("R10 quarter level 8", 32'(dma_req), 32'd1);
      rx_ctrl = mk(1, 1, 0, 7, 0, 0);
      @(negedge clk);
      chk("R10 half level 8", 32'(dma_req), 32'd0);
      send_frame(7, 16'h4646, 1'b1, 1'b0, 1'b1);
      chk("R10 half level 15", 32'(dma_req), 32'd0);
      rx_ctrl = mk(1, 1, 0, 1, 0, 0);
      send_frame(1, 16'h4747, 1'b1, 1'b0, 1'b1);
      chk("R10 half level 16", 32'(dma_req), 32'd1);
      drain("R10 drain");

      // R11 R12 full buffer
      do_reset();
      rx_ctrl = mk(1, 0, 0, 8, 0, 0);
      for (int f = 0; f < 4; f++)
         send_frame(8, 16'(16'h5000 + f), 1'b1, 1'b0, 1'b1);
      chk("R9 full flag", 32'(rd_full), 32'd1);
      chk("R9 full level", 32'(rd_level), 32'd32);
      rx_ctrl = mk(1, 0, 0, 1, 0, 0);
      send_frame(1, 16'h6001, 1'b1, 1'b1, 1'b1);
      chk("R12 level stays", 32'(rd_level), 32'd32);
      chk("R12 no overrun", 32'(overrun), 32'd0);
      send_frame(1, 16'h6002, 1'b1, 1'b0, 1'b1);
      chk("R11 overrun set", 32'(overrun), 32'd1);
      chk("R11 level", 32'(rd_level), 32'd32);
      drain("R11 R12 drain order");
      chk("R11 overrun sticky", 32'(overrun), 32'd1);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule